// File: doc/BRIEF.md
# Two-Wire Register Port Slave

This block is the serial slave that lets a host controller load and inspect a 128-location byte register file over a two-wire bus. The clock and data lines are sampled on a fast system clock. The slave recognises bus start and stop conditions and collects 9-clock byte frames. It compares the first byte of each transfer against its write and read device addresses. Data reaches the slave on a dedicated input pin. Everything the slave sends back (acknowledges and read data) leaves on a separate push-pull output pin rather than an open-drain line.

In a write transfer, the byte after the device address loads an internal register pointer. Every byte after that comes out as a one-cycle write strobe carrying the pointer and the data, and the pointer then advances. A read transfer reuses the pointer left by an earlier write. The slave fetches the byte at the pointer through a combinational read port and shifts it out in inverted form. The pointer advances once per byte and wraps from the top of the 7-bit range back to zero. The host ends a read by returning a not-acknowledge.

Top module: `ser_reg_slave`

## Requirements
- R1: A falling edge on the data input while the serial clock is high is a start condition. It aborts any transfer in progress, clears the output pin and makes the next byte a device-address byte.
- R2: A rising edge on the data input while the serial clock is high is a stop condition. It returns the slave to idle with the output pin low, and the output stays low until the next start.
- R3: Each byte frame is 9 serial clocks. The first 8 carry bits MSB first, sampled at the rising clock edge, and the 9th is the acknowledge clock.
- R4: The write device address is 24h and the read device address is 25h. Any other address byte leaves the output low for the whole transfer and produces no write strobe.
- R5: The output pin is high throughout the acknowledge clock after a matching device address, after the register-address byte, and after each written data byte.
- R6: In a write, the byte after 24h loads the pointer from its low 7 bits (bit 7 ignored). Each following byte produces one single-cycle strobe with the pointer as address and the byte as data, then the pointer increments. There is no limit on the number of bytes.
- R7: The pointer wraps from 7Fh to 00h on both writes and reads.
- R8: After 25h, each data byte is the read-port value at the pointer, driven on the output pin inverted and MSB first. The pointer increments once per byte, and the read-port address always equals the pointer.
- R9: During a read, a high on the data input at the 9th clock (host not-acknowledge) keeps the output low until the next start.
- R10: The output pin changes only while the serial clock is low, except when a start or stop condition clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Serial data from the host |
| sda_o | output | 1 | Acknowledge and inverted read data to the host |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register address for the strobe |
| wr_data | output | 8 | Register data for the strobe |
| rd_addr | output | 7 | Current pointer, the address for the read port |
| rd_data | input | 8 | Register value at rd_addr |

## Verification
The assertions assume the host obeys the bus timing. Data moves only while the clock is low, except for start and stop. Each clock phase lasts several system cycles, so a synchronised edge is seen exactly once and a write strobe is never followed by another within one cycle. The stimulus holds each serial clock phase for eight system cycles. It changes data only in the middle of the low phase and builds start and stop only from a settled high clock. As a result, every condition that reaches the slave is intentional.

// File: rtl/srs_pkg.sv
package srs_pkg;
   localparam int BYTE_W = 8;
   localparam int BITCNT_W = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_REG,
      ST_WDATA,
      ST_RACK,
      ST_RDATA,
      ST_SKIP
   } srs_state_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
   parameter int WIDTH   = 2,
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= {WIDTH{RST_VAL}};
      else        chain[0] <= d;
   end

   generate
      if (STAGES > 1) begin : g_multi
         for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= {WIDTH{RST_VAL}};
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/srs_cond_det.sv
module srs_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic start,
   output logic stop,
   output logic rise,
   output logic fall
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign start = scl_s & scl_q & sda_q & ~sda_s;
   assign stop  = scl_s & scl_q & ~sda_q & sda_s;
   assign rise  = scl_s & ~scl_q;
   assign fall  = ~scl_s & scl_q;
endmodule

// File: rtl/srs_frame.sv
module srs_frame
   import srs_pkg::*;
#(
   parameter int          PTR_W    = 7,
   parameter logic [6:0]  DEV_ADDR = 7'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic              rise,
   input  logic              fall,
   input  logic              sda_s,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              sda_o,
   output logic              wr_stb,
   output logic [PTR_W-1:0]  wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [PTR_W-1:0]  ptr
);
   localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
   localparam logic [BYTE_W-1:0] ADDR_RD = {DEV_ADDR, 1'b1};
   localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

   srs_state_e          st;
   logic [BITCNT_W-1:0] bitcnt;
   logic                in_ack;
   logic [BYTE_W-1:0]   shreg;
   logic [BYTE_W-1:0]   tx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         bitcnt  <= '0;
         in_ack  <= 1'b0;
         shreg   <= '0;
         tx      <= '0;
         ptr     <= '0;
         sda_o   <= 1'b0;
         wr_stb  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_stb <= 1'b0;
         if (start) begin
            st     <= ST_DEV;
            bitcnt <= '0;
            in_ack <= 1'b0;
            sda_o  <= 1'b0;
         end else if (stop) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            in_ack <= 1'b0;
            sda_o  <= 1'b0;
         end else if (st != ST_IDLE) begin
            if (rise) begin
               if (bitcnt == LAST_BIT) begin
                  bitcnt <= '0;
                  if (st == ST_RDATA && sda_s) st <= ST_SKIP;
               end else begin
                  shreg  <= {shreg[BYTE_W-2:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
               end
            end
            if (fall) begin
               if (bitcnt == LAST_BIT) begin
                  in_ack <= 1'b1;
                  sda_o  <= 1'b0;
                  case (st)
                     ST_DEV: begin
                        if (shreg == ADDR_WR) begin
                           sda_o <= 1'b1;
                           st    <= ST_REG;
                        end else if (shreg == ADDR_RD) begin
                           sda_o <= 1'b1;
                           st    <= ST_RACK;
                        end else begin
                           st <= ST_SKIP;
                        end
                     end
                     ST_REG: begin
                        ptr   <= shreg[PTR_W-1:0];
                        sda_o <= 1'b1;
                        st    <= ST_WDATA;
                     end
                     ST_WDATA: begin
                        wr_stb  <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= shreg;
                        ptr     <= ptr + 1'b1;
                        sda_o   <= 1'b1;
                     end
                     default: ;
                  endcase
               end else if (bitcnt == '0 && in_ack) begin
                  in_ack <= 1'b0;
                  sda_o  <= 1'b0;
                  if (st == ST_RACK || st == ST_RDATA) begin
                     sda_o <= ~rd_data[BYTE_W-1];
                     tx    <= {rd_data[BYTE_W-2:0], 1'b0};
                     ptr   <= ptr + 1'b1;
                     st    <= ST_RDATA;
                  end
               end else if (st == ST_RDATA && bitcnt != '0) begin
                  sda_o <= ~tx[BYTE_W-1];
                  tx    <= {tx[BYTE_W-2:0], 1'b0};
               end
            end
         end
      end
   end
endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave
   import srs_pkg::*;
#(
   parameter int         PTR_W       = 7,
   parameter logic [6:0] DEV_ADDR    = 7'h12,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_o,
   output logic              wr_stb,
   output logic [PTR_W-1:0]  wr_addr,
   output logic [BYTE_W-1:0] wr_data,
   output logic [PTR_W-1:0]  rd_addr,
   input  logic [BYTE_W-1:0] rd_data
);
   initial begin
      if (PTR_W < 1 || PTR_W > BYTE_W - 1) $error("PTR_W must be 1..7");
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s;
   logic start_c, stop_c, rise_c, fall_c;

   srs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({scl_i, sda_i}),
      .q    ({scl_s, sda_s})
   );

   srs_cond_det i_det (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_s(scl_s),
      .sda_s(sda_s),
      .start(start_c),
      .stop (stop_c),
      .rise (rise_c),
      .fall (fall_c)
   );

   srs_frame #(.PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) i_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_c),
      .stop   (stop_c),
      .rise   (rise_c),
      .fall   (fall_c),
      .sda_s  (sda_s),
      .rd_data(rd_data),
      .sda_o  (sda_o),
      .wr_stb (wr_stb),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .ptr    (rd_addr)
   );
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
   parameter int PTR_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             start,
   input logic             stop,
   input logic             sda_o,
   input logic             wr_stb,
   input logic [PTR_W-1:0] wr_addr,
   input logic [PTR_W-1:0] rd_addr
);
   AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R6
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> rd_addr == PTR_W'($past(wr_addr) + 1'b1)); // R7
   AST_STB_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> !scl_s); // R3
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start |=> (!sda_o && !wr_stb)); // R1
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) stop |=> !sda_o); // R2
   AST_OUT_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(start) && !$past(stop) && sda_o != $past(sda_o)) |-> !$past(scl_s)); // R10
endmodule

bind ser_reg_slave srs_checker #(.PTR_W(PTR_W)) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .scl_s  (scl_s),
   .start  (start_c),
   .stop   (stop_c),
   .sda_o  (sda_o),
   .wr_stb (wr_stb),
   .wr_addr(wr_addr),
   .rd_addr(rd_addr)
);

// File: tb/test_ser_reg_slave.sv
module test_ser_reg_slave;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda = 1'b1;
   logic sda_o, wr_stb;
   logic [6:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data;
   logic [7:0] mem [128];
   int nchk = 0, nfail = 0, nstb = 0, unstable = 0;

   always #5 clk = ~clk;

   ser_reg_slave i_ser_reg_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_o(sda_o),
      .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   assign rd_data = mem[rd_addr];

   initial for (int i = 0; i < 128; i++) mem[i] = 8'h00;

   always @(posedge clk) if (wr_stb) begin
      mem[wr_addr] <= wr_data;
      nstb++;
   end

   function automatic logic [7:0] fsweep(int i);
      return 8'((i * 37) + 11);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_bit(input logic b, output logic o);
      logic o1;
      tick(4); sda = b;
      tick(4); scl = 1'b1;
      tick(1); o1 = sda_o;
      tick(5); o = sda_o;
      if (o1 !== o) unstable++;
      tick(2); scl = 1'b0;
   endtask

   task automatic bus_start();
      tick(4); sda = 1'b1;
      tick(4); scl = 1'b1;
      tick(8); sda = 1'b0;
      tick(8); scl = 1'b0;
   endtask

   task automatic bus_stop();
      tick(4); sda = 1'b0;
      tick(4); scl = 1'b1;
      tick(8); sda = 1'b1;
      tick(8);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic d;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], d);
      bus_bit(1'b1, ack);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      logic o, d;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, o);
         b[i] = ~o;
      end
      bus_bit(mack, d);
   endtask

   task automatic set_ptr(input logic [7:0] p);
      logic a;
      bus_start(); send_byte(8'h24, a); send_byte(p, a); bus_stop();
   endtask

   initial begin : main
      logic a0, a1, a2, o;
      logic [7:0] rb;
      int base;
      tick(5); rst_n = 1'b1; tick(5);
      chk(sda_o == 1'b0, "R2 reset output", sda_o, 0);
      chk(wr_stb == 1'b0, "R6 reset strobe", wr_stb, 0);

      // single write
      bus_start(); send_byte(8'h24, a0); send_byte(8'h03, a1); send_byte(8'hA5, a2); bus_stop();
      chk(a0 == 1'b1, "R5 device ack", a0, 1);
      chk(a1 == 1'b1, "R5 register ack", a1, 1);
      chk(a2 == 1'b1, "R5 data ack", a2, 1);
      chk(mem[3] == 8'hA5, "R6 single write", mem[3], 8'hA5);
      chk(nstb == 1, "R6 strobe count", nstb, 1);
      chk(sda_o == 1'b0, "R2 idle after stop", sda_o, 0);

      // full sweep burst
      base = nstb;
      bus_start(); send_byte(8'h24, a0); send_byte(8'h00, a1);
      for (int i = 0; i < 128; i++) send_byte(fsweep(i), a2);
      bus_stop();
      chk(nstb - base == 128, "R6 burst strobes", nstb - base, 128);
      for (int i = 0; i < 128; i++)
         chk(mem[i] == fsweep(i), "R3 R6 burst data", mem[i], fsweep(i));

      // write wrap
      bus_start(); send_byte(8'h24, a0); send_byte(8'h7E, a1);
      for (int k = 0; k < 4; k++) send_byte(8'hC0 + 8'(k), a2);
      bus_stop();
      chk(mem[126] == 8'hC0, "R7 write 7E", mem[126], 8'hC0);
      chk(mem[127] == 8'hC1, "R7 write 7F", mem[127], 8'hC1);
      chk(mem[0] == 8'hC2, "R7 write wrap 00", mem[0], 8'hC2);
      chk(mem[1] == 8'hC3, "R7 write wrap 01", mem[1], 8'hC3);

      // bit 7 of register address ignored
      bus_start(); send_byte(8'h24, a0); send_byte(8'h85, a1); send_byte(8'h3C, a2); bus_stop();
      chk(mem[5] == 8'h3C, "R6 pointer bit7 ignored", mem[5], 8'h3C);

      // read burst with final nack
      set_ptr(8'h10);
      bus_start(); send_byte(8'h25, a0);
      chk(a0 == 1'b1, "R4 R5 read address ack", a0, 1);
      for (int k = 0; k < 5; k++) begin
         recv_byte(k == 4, rb);
         chk(rb == fsweep(16 + k), "R8 read data", rb, fsweep(16 + k));
      end
      chk(rd_addr == 7'h15, "R8 pointer after read", rd_addr, 7'h15);
      a1 = 1'b0;
      for (int i = 0; i < 9; i++) begin
         bus_bit(1'b1, o);
         a1 = a1 | o;
      end
      chk(a1 == 1'b0, "R9 silent after nack", a1, 0);
      bus_stop();

      // read wrap
      set_ptr(8'h7F);
      bus_start(); send_byte(8'h25, a0);
      recv_byte(1'b0, rb);
      chk(rb == 8'hC1, "R7 read 7F", rb, 8'hC1);
      recv_byte(1'b1, rb);
      chk(rb == 8'hC2, "R7 read wrap 00", rb, 8'hC2);
      bus_stop();

      // aborted transfer then restart
      bus_start();
      for (int i = 0; i < 3; i++) bus_bit(1'b0, o);
      bus_start(); send_byte(8'h24, a0); send_byte(8'h20, a1); send_byte(8'h5A, a2); bus_stop();
      chk(a0 == 1'b1, "R1 ack after restart", a0, 1);
      chk(mem[32] == 8'h5A, "R1 write after restart", mem[32], 8'h5A);

      // device address sweep
      for (int ad = 0; ad < 256; ad++) begin
         base = nstb;
         bus_start(); send_byte(8'(ad), a0);
         chk(a0 == (ad == 8'h24 || ad == 8'h25), "R4 address match", a0, (ad == 8'h24 || ad == 8'h25));
         if (ad != 8'h24 && ad != 8'h25 && (ad % 16) == 0) begin
            send_byte(8'h01, a1); send_byte(8'hEE, a2);
            chk(a1 == 1'b0 && a2 == 1'b0 && nstb == base, "R4 foreign transfer ignored", nstb - base, 0);
         end
         bus_stop();
      end

      chk(unstable == 0, "R10 output stable while clock high", unstable, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule